// File: doc/BRIEF.md
# Multiprocessor-Aware Asynchronous Serial Receiver

This block receives asynchronous serial characters: a low start bit, eight data bits sent least significant bit first, an optional ninth bit, and a high stop bit. A two-bit source field selects how the block is timed. The timing is either an internal sub-bit tick pulse from a baud generator outside the block, or a clock taken in on a shared clock pin that runs at sixteen times the bit rate. The block also reports whether the shared pin is driven, and when it is driven it supplies a clock at the bit rate. Every bit lasts sixteen sub-bit ticks. A completed character is moved from the shift register into a data register. Framing, parity and overrun errors raise sticky flags, and each flag is cleared by a pulse on its own acknowledge input.

In multiprocessor format the ninth bit tags a character as an address (1) or as data (0). Software arms a wait state. While the wait is armed, data characters vanish without trace: nothing is loaded and no flag changes. The first address character is taken normally, records its tag and disarms the wait by hardware. Outside multiprocessor format the ninth bit, when enabled, is a parity bit.

The framing state machine has five states. RX_IDLE goes to RX_START on a tick that sees the line low. RX_START goes to RX_DATA if the line is still low on the 8th tick, and back to RX_IDLE if it is not. RX_DATA shifts one bit every 16 ticks. After the eighth bit it goes to RX_EXTRA when a ninth bit is configured, and to RX_STOP otherwise. RX_EXTRA goes to RX_STOP after sampling the ninth bit. RX_STOP samples the stop bit, emits a completion pulse and returns to RX_IDLE. Dropping the receive enable forces RX_IDLE from any state.

Top module: `mp_uart_rx`

## Requirements
- R1: The source field `clk_sel` selects the timing and the pin direction. 2'b00 uses the internal tick and leaves the pin undriven (`sck_oe`=0). 2'b01 uses the internal tick and drives the pin (`sck_oe`=1). 2'b10 and 2'b11 both use ticks from `ext_clk`, with the pin undriven.
- R2: With `clk_sel`=2'b01, `sck_out` makes exactly one rising edge per 16 internal ticks, which is the bit rate. While the pin is not driven, `sck_out` is 0.
- R3: A character starts only while `rx_en` is 1. The 8 data bits are sampled every 16 ticks, LSB first. One clock after the stop-bit sample, `rx_data` takes the character and `full` becomes 1, provided `full` was 0.
- R4: A start bit is confirmed only if the line is still low on the 8th tick after detection. Otherwise the receiver returns to idle, and nothing is loaded or flagged.
- R5: A stop-bit sample of 0 sets `frm_err`, together with the load of that character.
- R6: With `parity_en`=1 and `mp_mode`=0, the ninth bit is parity: even parity when `parity_odd`=0 and odd parity when it is 1. A mismatch sets `par_err` together with the load.
- R7: A character that completes while `full`=1 sets `ovr_err`. `rx_data`, `full`, `frm_err`, `par_err` and `mp_bit` keep their values.
- R8: With `mp_mode`=1 and `mp_wait`=1, a character whose ninth bit is 0 changes no output at all, whatever its stop bit.
- R9: In `mp_mode`, a character with ninth bit 1 clears `mp_wait` (armed by a `mp_wait_set` pulse) and is then handled by R3, R5 and R7. Every loaded character copies its ninth bit into `mp_bit`.
- R10: In the external modes, each rising edge of `ext_clk` is one sub-bit tick, acting three clocks after the edge. Pulses on `int_tick` are ignored. In the internal modes, `ext_clk` is ignored.
- R11: Clearing `rx_en` aborts any character in progress and leaves all flags and `rx_data` unchanged.
- R12: A one-clock pulse on `ack_full`, `ack_frm`, `ack_par` or `ack_ovr` clears only its own flag on the next clock. A set in that same clock wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_sel | input | 2 | Timing source and pin direction select |
| int_tick | input | 1 | Internal sub-bit tick pulse, 16 per bit |
| ext_clk | input | 1 | Clock taken in on the shared pin, 16x bit rate |
| sck_out | output | 1 | Bit-rate clock driven onto the shared pin |
| sck_oe | output | 1 | Drive enable for the shared pin |
| rx_en | input | 1 | Receive enable |
| rx_line | input | 1 | Serial input, idle high |
| mp_mode | input | 1 | Multiprocessor character format |
| parity_en | input | 1 | Ninth bit is parity when not in multiprocessor format |
| parity_odd | input | 1 | Odd parity when 1, even when 0 |
| mp_wait_set | input | 1 | Pulse that arms the address wait |
| ack_full | input | 1 | Pulse that clears `full` |
| ack_frm | input | 1 | Pulse that clears `frm_err` |
| ack_par | input | 1 | Pulse that clears `par_err` |
| ack_ovr | input | 1 | Pulse that clears `ovr_err` |
| rx_data | output | 8 | Last loaded character |
| full | output | 1 | Data register holds an unread character |
| frm_err | output | 1 | Sticky framing error |
| par_err | output | 1 | Sticky parity error |
| ovr_err | output | 1 | Sticky overrun error |
| mp_bit | output | 1 | Ninth bit of the last loaded character |
| mp_wait | output | 1 | Address wait armed |

## Verification
Several relations are checked on every cycle. The pin enable must follow the source field, and the pin must stay quiet when undriven. An error flag may only rise together with a load. An overrun must leave the data register untouched. A load that happens during an armed wait must be an address character that disarms the wait. Flags must hold while reception is disabled. Other behaviours need driven scenarios, and the bench's cycle-exact model compares every output on every clock. Those behaviours are the bit order and sampling phase, the rejection of short start glitches, the silent discard of data characters during the wait, parity in both senses, the abort by the enable, the exact bit-rate clock on the pin, and the fact that only the selected tick source drives timing.

// File: rtl/mpr_pkg.sv
package mpr_pkg;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_EXTRA,
        RX_STOP
    } rx_state_e;

    typedef enum logic [1:0] {
        SRC_INT_QUIET = 2'b00,
        SRC_INT_DRIVE = 2'b01,
        SRC_EXT_A     = 2'b10,
        SRC_EXT_B     = 2'b11
    } clk_src_e;

endpackage

// File: rtl/mpr_clk_src.sv
module mpr_clk_src
    import mpr_pkg::*;
#(
    parameter int OSR         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] clk_sel,
    input  logic       int_tick,
    input  logic       ext_clk,
    output logic       tick,
    output logic       sck_out,
    output logic       sck_oe
);
    localparam int DIV_W = $clog2(OSR);

    logic [SYNC_STAGES:0] ext_sh;
    logic [DIV_W-1:0]     div_q;
    logic                 ext_edge;
    logic                 use_ext;
    logic                 drive_pin;

    // synchroniser plus one history stage for edge detection
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ext_sh <= '0;
        end else begin
            ext_sh <= {ext_sh[SYNC_STAGES-1:0], ext_clk};
        end
    end

    assign ext_edge = ext_sh[SYNC_STAGES-1] & ~ext_sh[SYNC_STAGES];

    // free-running divider of internal ticks: top bit is the bit-rate clock
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (int_tick) begin
            div_q <= div_q + 1'b1;
        end
    end

    always_comb begin
        use_ext   = 1'b0;
        drive_pin = 1'b0;
        unique case (clk_src_e'(clk_sel))
            SRC_INT_QUIET: begin use_ext = 1'b0; drive_pin = 1'b0; end
            SRC_INT_DRIVE: begin use_ext = 1'b0; drive_pin = 1'b1; end
            SRC_EXT_A:     begin use_ext = 1'b1; drive_pin = 1'b0; end
            SRC_EXT_B:     begin use_ext = 1'b1; drive_pin = 1'b0; end
            default:       begin use_ext = 1'b0; drive_pin = 1'b0; end
        endcase
    end

    assign tick    = use_ext ? ext_edge : int_tick;
    assign sck_oe  = drive_pin;
    assign sck_out = drive_pin & div_q[DIV_W-1];

endmodule

// File: rtl/mpr_line_sync.sv
module mpr_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sh <= '1;
                else        sh <= d;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sh <= '1;
                else        sh <= {sh[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = sh[STAGES-1];

endmodule

// File: rtl/mpr_rx_fsm.sv
module mpr_rx_fsm
    import mpr_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OSR    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              line,
    input  logic              rx_en,
    input  logic              extra_en,
    output logic              done,
    output logic [DATA_W-1:0] shreg,
    output logic              extra_bit,
    output logic              stop_ok
);
    localparam int CW = $clog2(OSR);
    localparam int BW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(OSR - 1);
    localparam logic [CW-1:0] CNT_MID  = CW'(OSR / 2 - 1);
    localparam logic [BW-1:0] BIT_LAST = BW'(DATA_W - 1);

    rx_state_e         state_q, state_n;
    logic [CW-1:0]     cnt_q, cnt_n;
    logic [BW-1:0]     bidx_q, bidx_n;
    logic [DATA_W-1:0] sh_q, sh_n;
    logic              ex_q, ex_n;
    logic              stop_q, stop_n;
    logic              done_q, done_n;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RX_IDLE;
            cnt_q   <= '0;
            bidx_q  <= '0;
            sh_q    <= '0;
            ex_q    <= 1'b0;
            stop_q  <= 1'b1;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_n;
            cnt_q   <= cnt_n;
            bidx_q  <= bidx_n;
            sh_q    <= sh_n;
            ex_q    <= ex_n;
            stop_q  <= stop_n;
            done_q  <= done_n;
        end
    end

    // next state and outputs
    always_comb begin
        state_n = state_q;
        cnt_n   = cnt_q;
        bidx_n  = bidx_q;
        sh_n    = sh_q;
        ex_n    = ex_q;
        stop_n  = stop_q;
        done_n  = 1'b0;

        if (!rx_en) begin
            state_n = RX_IDLE;
            cnt_n   = '0;
        end else if (tick) begin
            unique case (state_q)
                RX_IDLE: begin
                    if (!line) begin
                        state_n = RX_START;
                        cnt_n   = CW'(1);
                    end
                end
                RX_START: begin
                    if (cnt_q == CNT_MID) begin
                        cnt_n   = '0;
                        bidx_n  = '0;
                        state_n = line ? RX_IDLE : RX_DATA;
                    end else begin
                        cnt_n = cnt_q + 1'b1;
                    end
                end
                RX_DATA: begin
                    if (cnt_q == CNT_LAST) begin
                        cnt_n = '0;
                        sh_n  = {line, sh_q[DATA_W-1:1]};
                        if (bidx_q == BIT_LAST) begin
                            state_n = extra_en ? RX_EXTRA : RX_STOP;
                        end else begin
                            bidx_n = bidx_q + 1'b1;
                        end
                    end else begin
                        cnt_n = cnt_q + 1'b1;
                    end
                end
                RX_EXTRA: begin
                    if (cnt_q == CNT_LAST) begin
                        cnt_n   = '0;
                        ex_n    = line;
                        state_n = RX_STOP;
                    end else begin
                        cnt_n = cnt_q + 1'b1;
                    end
                end
                RX_STOP: begin
                    if (cnt_q == CNT_LAST) begin
                        cnt_n   = '0;
                        stop_n  = line;
                        done_n  = 1'b1;
                        state_n = RX_IDLE;
                    end else begin
                        cnt_n = cnt_q + 1'b1;
                    end
                end
                default: begin
                    state_n = RX_IDLE;
                    cnt_n   = '0;
                end
            endcase
        end
    end

    assign done      = done_q;
    assign shreg     = sh_q;
    assign extra_bit = ex_q;
    assign stop_ok   = stop_q;

endmodule

// File: rtl/mpr_result.sv
module mpr_result #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done,
    input  logic [DATA_W-1:0] shreg,
    input  logic              extra_bit,
    input  logic              stop_ok,
    input  logic              mp_mode,
    input  logic              parity_en,
    input  logic              parity_odd,
    input  logic              mp_wait_set,
    input  logic              ack_full,
    input  logic              ack_frm,
    input  logic              ack_par,
    input  logic              ack_ovr,
    output logic [DATA_W-1:0] rx_data,
    output logic              full,
    output logic              frm_err,
    output logic              par_err,
    output logic              ovr_err,
    output logic              mp_bit,
    output logic              mp_wait
);
    logic discard;
    logic accept;
    logic wake;
    logic par_bad;

    assign discard = mp_mode & mp_wait & ~extra_bit;
    assign accept  = done & ~discard;
    assign wake    = accept & mp_mode & mp_wait;
    assign par_bad = parity_en & ~mp_mode & ((^shreg) ^ extra_bit ^ parity_odd);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_data <= '0;
            full    <= 1'b0;
            frm_err <= 1'b0;
            par_err <= 1'b0;
            ovr_err <= 1'b0;
            mp_bit  <= 1'b0;
            mp_wait <= 1'b0;
        end else begin
            if (ack_full) full    <= 1'b0;
            if (ack_frm)  frm_err <= 1'b0;
            if (ack_par)  par_err <= 1'b0;
            if (ack_ovr)  ovr_err <= 1'b0;
            if (wake)        mp_wait <= 1'b0;
            if (mp_wait_set) mp_wait <= 1'b1;
            if (accept) begin
                if (full) begin
                    ovr_err <= 1'b1;
                end else begin
                    rx_data <= shreg;
                    full    <= 1'b1;
                    if (!stop_ok) frm_err <= 1'b1;
                    if (par_bad)  par_err <= 1'b1;
                    if (mp_mode)  mp_bit  <= extra_bit;
                end
            end
        end
    end

endmodule

// File: rtl/mp_uart_rx.sv
module mp_uart_rx #(
    parameter int DATA_W      = 8,
    parameter int OSR         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        clk_sel,
    input  logic              int_tick,
    input  logic              ext_clk,
    output logic              sck_out,
    output logic              sck_oe,
    input  logic              rx_en,
    input  logic              rx_line,
    input  logic              mp_mode,
    input  logic              parity_en,
    input  logic              parity_odd,
    input  logic              mp_wait_set,
    input  logic              ack_full,
    input  logic              ack_frm,
    input  logic              ack_par,
    input  logic              ack_ovr,
    output logic [DATA_W-1:0] rx_data,
    output logic              full,
    output logic              frm_err,
    output logic              par_err,
    output logic              ovr_err,
    output logic              mp_bit,
    output logic              mp_wait
);
    logic              tick;
    logic              line_s;
    logic              done;
    logic [DATA_W-1:0] shreg;
    logic              extra_bit;
    logic              stop_ok;

    mpr_clk_src #(.OSR(OSR), .SYNC_STAGES(SYNC_STAGES)) u_src (
        .clk      (clk),
        .rst_n    (rst_n),
        .clk_sel  (clk_sel),
        .int_tick (int_tick),
        .ext_clk  (ext_clk),
        .tick     (tick),
        .sck_out  (sck_out),
        .sck_oe   (sck_oe)
    );

    mpr_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (rx_line),
        .q     (line_s)
    );

    mpr_rx_fsm #(.DATA_W(DATA_W), .OSR(OSR)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .line      (line_s),
        .rx_en     (rx_en),
        .extra_en  (mp_mode | parity_en),
        .done      (done),
        .shreg     (shreg),
        .extra_bit (extra_bit),
        .stop_ok   (stop_ok)
    );

    mpr_result #(.DATA_W(DATA_W)) u_res (
        .clk         (clk),
        .rst_n       (rst_n),
        .done        (done),
        .shreg       (shreg),
        .extra_bit   (extra_bit),
        .stop_ok     (stop_ok),
        .mp_mode     (mp_mode),
        .parity_en   (parity_en),
        .parity_odd  (parity_odd),
        .mp_wait_set (mp_wait_set),
        .ack_full    (ack_full),
        .ack_frm     (ack_frm),
        .ack_par     (ack_par),
        .ack_ovr     (ack_ovr),
        .rx_data     (rx_data),
        .full        (full),
        .frm_err     (frm_err),
        .par_err     (par_err),
        .ovr_err     (ovr_err),
        .mp_bit      (mp_bit),
        .mp_wait     (mp_wait)
    );

endmodule

// File: rtl/mpr_checker.sv
module mpr_checker #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        clk_sel,
    input logic              sck_out,
    input logic              sck_oe,
    input logic              rx_en,
    input logic              mp_mode,
    input logic              mp_wait_set,
    input logic              ack_full,
    input logic              ack_frm,
    input logic              ack_par,
    input logic              ack_ovr,
    input logic [DATA_W-1:0] rx_data,
    input logic              full,
    input logic              frm_err,
    input logic              par_err,
    input logic              ovr_err,
    input logic              mp_bit,
    input logic              mp_wait
);
    logic any_ack;
    assign any_ack = ack_full | ack_frm | ack_par | ack_ovr;

    // R1: the pin is driven only for the internal-drive selection
    assert_pin_dir_R1: assert property (@(posedge clk) disable iff (!rst_n)
        sck_oe |-> (clk_sel == 2'b01));

    // R2: an undriven pin carries no clock
    assert_pin_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !sck_oe |-> !sck_out);

    // R5: framing error only appears with a load
    assert_frm_with_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frm_err) |-> $rose(full));

    // R6: parity error only appears with a load
    assert_par_with_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(par_err) |-> $rose(full));

    // R7: overrun leaves the data register alone
    assert_ovr_keeps_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr_err) |-> ($stable(rx_data) && full));

    // R8: a load during an armed wait must be the address that disarms it
    assert_filter_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(full) && $past(mp_mode) && $past(mp_wait) && !$past(mp_wait_set))
        |-> !mp_wait);

    // R9: the wait is only dropped by an address character
    assert_wake_tag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mp_wait) |-> mp_bit || ovr_err);

    // R11: with reception off, nothing changes apart from acknowledges
    assert_hold_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_en && !$past(rx_en) && !$past(rx_en, 2) && !$past(any_ack))
        |-> ($stable(full) && $stable(frm_err) && $stable(par_err)
             && $stable(ovr_err) && $stable(rx_data)));

endmodule

bind mp_uart_rx mpr_checker #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .clk_sel     (clk_sel),
    .sck_out     (sck_out),
    .sck_oe      (sck_oe),
    .rx_en       (rx_en),
    .mp_mode     (mp_mode),
    .mp_wait_set (mp_wait_set),
    .ack_full    (ack_full),
    .ack_frm     (ack_frm),
    .ack_par     (ack_par),
    .ack_ovr     (ack_ovr),
    .rx_data     (rx_data),
    .full        (full),
    .frm_err     (frm_err),
    .par_err     (par_err),
    .ovr_err     (ovr_err),
    .mp_bit      (mp_bit),
    .mp_wait     (mp_wait)
);

// File: tb/sim_mp_uart_rx.sv
module sim_mp_uart_rx;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] clk_sel = 2'b00;
    logic       int_tick = 1'b0;
    logic       ext_clk = 1'b0;
    logic       sck_out, sck_oe;
    logic       rx_en = 1'b0;
    logic       rx_line = 1'b1;
    logic       mp_mode = 1'b0;
    logic       parity_en = 1'b0;
    logic       parity_odd = 1'b0;
    logic       mp_wait_set = 1'b0;
    logic       ack_full = 1'b0, ack_frm = 1'b0, ack_par = 1'b0, ack_ovr = 1'b0;
    logic [7:0] rx_data;
    logic       full, frm_err, par_err, ovr_err, mp_bit, mp_wait;

    int n_tests = 0;
    int n_fail  = 0;
    bit cmp_on  = 1'b0;
    bit done_run = 1'b0;

    // reference model state
    logic [7:0] e_data = '0;
    logic e_full = 0, e_frm = 0, e_par = 0, e_ovr = 0, e_mpb = 0, e_wait = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mp_uart_rx u0 (
        .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .int_tick(int_tick),
        .ext_clk(ext_clk), .sck_out(sck_out), .sck_oe(sck_oe), .rx_en(rx_en),
        .rx_line(rx_line), .mp_mode(mp_mode), .parity_en(parity_en),
        .parity_odd(parity_odd), .mp_wait_set(mp_wait_set), .ack_full(ack_full),
        .ack_frm(ack_frm), .ack_par(ack_par), .ack_ovr(ack_ovr), .rx_data(rx_data),
        .full(full), .frm_err(frm_err), .par_err(par_err), .ovr_err(ovr_err),
        .mp_bit(mp_bit), .mp_wait(mp_wait)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (cmp_on && !done_run) begin
            chk(rx_data == e_data, "R3", "rx_data", rx_data, e_data);
            chk(full == e_full,    "R3", "full",    full,    e_full);
            chk(frm_err == e_frm,  "R5", "frm_err", frm_err, e_frm);
            chk(par_err == e_par,  "R6", "par_err", par_err, e_par);
            chk(ovr_err == e_ovr,  "R7", "ovr_err", ovr_err, e_ovr);
            chk(mp_bit == e_mpb,   "R9", "mp_bit",  mp_bit,  e_mpb);
            chk(mp_wait == e_wait, "R8", "mp_wait", mp_wait, e_wait);
        end
    end

    // behavioural model of one completed character
    task automatic model_char(input logic [7:0] d, input logic ex, input logic stp);
        if (mp_mode && e_wait && !ex) return;
        if (mp_mode && e_wait) e_wait = 1'b0;
        if (e_full) begin
            e_ovr = 1'b1;
        end else begin
            e_data = d;
            e_full = 1'b1;
            if (!stp) e_frm = 1'b1;
            if (parity_en && !mp_mode && (((^d) ^ ex) != parity_odd)) e_par = 1'b1;
            if (mp_mode) e_mpb = ex;
        end
    endtask

    // one sub-bit tick period of four clocks from the selected source
    task automatic one_tick(input logic lv);
        bit ext_sel;
        ext_sel = clk_sel[1];
        @(negedge clk); rx_line = lv; if (ext_sel) ext_clk = 1'b1;
        @(negedge clk); if (ext_sel) int_tick = 1'b1; else ext_clk = 1'b1;
        @(negedge clk);
        if (ext_sel) begin int_tick = 1'b0; ext_clk = 1'b0; end
        else int_tick = 1'b1;
        @(negedge clk); if (!ext_sel) begin int_tick = 1'b0; ext_clk = 1'b0; end
    endtask

    task automatic send_char(input logic [7:0] d, input logic ex, input logic stp,
                             input int abort_at);
        int   nb;
        int   stop_tick;
        bit   live;
        logic bits[11];
        nb = (mp_mode || parity_en) ? 11 : 10;
        bits[0] = 1'b0;
        for (int i = 0; i < 8; i++) bits[i+1] = d[i];
        if (nb == 11) bits[9] = ex;
        bits[nb-1] = stp;
        stop_tick = 16*(nb-1) + 7;
        live = rx_en;
        for (int t = 0; t < 16*nb; t++) begin
            logic lv;
            if (t == abort_at) begin rx_en = 1'b0; live = 1'b0; end
            lv = (t > stop_tick) ? 1'b1 : bits[t/16];
            one_tick(lv);
            if (t == stop_tick && live) begin
                @(posedge clk);
                model_char(d, (nb == 11) ? ex : 1'b0, stp);
            end
        end
    endtask

    task automatic ack(input logic [3:0] m);
        @(negedge clk); {ack_full, ack_frm, ack_par, ack_ovr} = m;
        @(posedge clk);
        if (m[3]) e_full = 1'b0;
        if (m[2]) e_frm  = 1'b0;
        if (m[1]) e_par  = 1'b0;
        if (m[0]) e_ovr  = 1'b0;
        @(negedge clk); {ack_full, ack_frm, ack_par, ack_ovr} = 4'b0;
    endtask

    task automatic arm_wait();
        @(negedge clk); mp_wait_set = 1'b1;
        @(posedge clk); e_wait = 1'b1;
        @(negedge clk); mp_wait_set = 1'b0;
    endtask

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!done_run) begin
            done_run = 1'b1;
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int rises;
        logic prev;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state
        chk({full, frm_err, par_err, ovr_err, mp_bit, mp_wait} == 6'b0, "R3",
            "reset flags", {full, frm_err, par_err, ovr_err, mp_bit, mp_wait}, 0);
        chk(rx_data == 8'h00, "R3", "reset data", rx_data, 0);
        cmp_on = 1'b1;

        // R1 / R2: pin direction and bit-rate clock
        chk(sck_oe == 1'b0 && sck_out == 1'b0, "R1", "sel00 pin", {sck_oe, sck_out}, 0);
        clk_sel = 2'b01; @(negedge clk);
        chk(sck_oe == 1'b1, "R1", "sel01 oe", sck_oe, 1);
        rises = 0; prev = sck_out;
        for (int k = 0; k < 32; k++) begin
            one_tick(1'b1);
            if (sck_out && !prev) rises++;
            prev = sck_out;
        end
        chk(rises == 2, "R2", "sck rises per 32 ticks", rises, 2);
        clk_sel = 2'b10; @(negedge clk);
        chk(sck_oe == 1'b0 && sck_out == 1'b0, "R1", "sel10 pin", {sck_oe, sck_out}, 0);
        clk_sel = 2'b11; @(negedge clk);
        chk(sck_oe == 1'b0, "R1", "sel11 oe", sck_oe, 0);
        clk_sel = 2'b00; @(negedge clk);
        chk(sck_oe == 1'b0, "R1", "sel00 oe", sck_oe, 0);

        // R3: plain characters with the internal tick
        rx_en = 1'b1;
        send_char(8'hA5, 1'b0, 1'b1, -1);
        chk(rx_data == 8'hA5 && full, "R3", "char A5", rx_data, 8'hA5);
        ack(4'b1000);
        send_char(8'h3C, 1'b0, 1'b1, -1);
        chk(rx_data == 8'h3C, "R3", "char 3C", rx_data, 8'h3C);
        ack(4'b1000);

        // R4: short start glitch is rejected
        for (int t = 0; t < 24; t++) one_tick(t < 4 ? 1'b0 : 1'b1);
        chk(full == 1'b0, "R4", "glitch loads nothing", full, 0);
        send_char(8'h96, 1'b0, 1'b1, -1);
        chk(rx_data == 8'h96, "R4", "char after glitch", rx_data, 8'h96);
        ack(4'b1000);

        // R5: bad stop bit
        send_char(8'h5A, 1'b0, 1'b0, -1);
        chk(frm_err && full && rx_data == 8'h5A, "R5", "framing", frm_err, 1);
        // R12: acknowledge clears only its own flag
        ack(4'b0100);
        chk(!frm_err && full, "R12", "ack frm keeps full", full, 1);
        ack(4'b1000);

        // R6: parity in both senses
        parity_en = 1'b1; parity_odd = 1'b0;
        send_char(8'h07, 1'b1, 1'b1, -1);
        chk(!par_err, "R6", "even ok", par_err, 0);
        ack(4'b1000);
        send_char(8'h07, 1'b0, 1'b1, -1);
        chk(par_err, "R6", "even bad", par_err, 1);
        ack(4'b1010);
        parity_odd = 1'b1;
        send_char(8'h07, 1'b0, 1'b1, -1);
        chk(!par_err, "R6", "odd ok", par_err, 0);
        ack(4'b1000);
        parity_en = 1'b0;

        // R7: overrun keeps first character
        send_char(8'h11, 1'b0, 1'b1, -1);
        send_char(8'h22, 1'b0, 1'b0, -1);
        chk(ovr_err && rx_data == 8'h11 && !frm_err, "R7", "overrun", rx_data, 8'h11);
        ack(4'b1001);

        // R8 / R9: address wait
        mp_mode = 1'b1;
        arm_wait();
        send_char(8'h33, 1'b0, 1'b0, -1);
        send_char(8'h44, 1'b0, 1'b1, -1);
        chk(!full && !frm_err && mp_wait, "R8", "data discarded", full, 0);
        send_char(8'h55, 1'b1, 1'b1, -1);
        chk(full && mp_bit && !mp_wait && rx_data == 8'h55, "R9", "address wakes",
            rx_data, 8'h55);
        ack(4'b1000);
        send_char(8'h66, 1'b0, 1'b1, -1);
        chk(rx_data == 8'h66 && !mp_bit, "R9", "data after wake", rx_data, 8'h66);
        arm_wait();
        send_char(8'h67, 1'b1, 1'b1, -1);
        chk(ovr_err && !mp_wait && rx_data == 8'h66, "R9", "wake with overrun",
            rx_data, 8'h66);
        ack(4'b1001);
        mp_mode = 1'b0;

        // R11: disable holds flags and aborts a character
        send_char(8'h12, 1'b0, 1'b0, -1);
        rx_en = 1'b0;
        send_char(8'h34, 1'b0, 1'b1, -1);
        chk(full && frm_err && rx_data == 8'h12, "R11", "held while off", rx_data, 8'h12);
        rx_en = 1'b1;
        ack(4'b1100);
        send_char(8'hC3, 1'b0, 1'b1, 60);
        chk(!full, "R11", "abort loads nothing", full, 0);
        rx_en = 1'b1;
        send_char(8'h77, 1'b0, 1'b1, -1);
        chk(rx_data == 8'h77, "R11", "char after abort", rx_data, 8'h77);
        ack(4'b1000);

        // R10: external clock, both encodings
        clk_sel = 2'b10;
        send_char(8'h81, 1'b0, 1'b1, -1);
        chk(rx_data == 8'h81, "R10", "ext 10", rx_data, 8'h81);
        ack(4'b1000);
        clk_sel = 2'b11;
        send_char(8'h18, 1'b0, 1'b1, -1);
        chk(rx_data == 8'h18, "R10", "ext 11", rx_data, 8'h18);
        ack(4'b1000);
        clk_sel = 2'b00;

        repeat (4) @(negedge clk);
        done_run = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule